// File: doc/BRIEF.md
# Interrupt Request Flag Register

This block is a byte-wide interrupt request flag register for a small microcontroller. Eight flag positions gather requests from three kinds of source. A timer-wrap strobe arrives when an 8-bit timer counter rolls over from 0xFF to 0x00. A transfer-done strobe arrives when a serial transfer finishes. Five external interrupt pins each have their own edge detector. Software reads the whole byte at any time and can only take a flag down, by writing 0 to it. A combined request output tells the interrupt controller that at least one enabled flag is pending.

Each external pin passes through a two-stage synchroniser before its edge detector. The pin raises its flag only when its pin-mode enable bit is 1, and only on the edge its edge-select bit picks. A build-time option drops the serial flag and external flag 2 so that both read as 0. Timer, serial interface, enable masking and priority logic sit outside the block.

Top module: `irq_flag_reg`

## Requirements
- R1: After reset every implemented flag is 0 and `rd_data` reads 0x20.
- R2: Bit 7 holds the timer flag and bit 6 the serial flag. A one-cycle `timer_wrap` or `xfer_done` strobe sampled at a rising edge sets its flag, and the flag is visible on `rd_data` right after that edge.
- R3: Bit 5 always reads 1, and writing to it (with 0 or 1) changes nothing.
- R4: Bits 4..0 are the flags of pins 4..0. A pin with `pin_irq_mode[i]`=1 sets flag i on the edge picked by `edge_rise[i]` (1 = low-to-high, 0 = high-to-low). A level change that the bench drives between two edges shows on `rd_data` after the third rising edge and not after the second. The other edge direction has no effect.
- R5: A pin whose `pin_irq_mode[i]` is 0 never sets its flag, whatever its edges.
- R6: A write (`wr_en`=1) with a 0 in a bit that reads 1 clears that flag at the sampling edge.
- R7: Writing 1 to a flag bit leaves it unchanged. Software can never set a flag.
- R8: When a hardware set and a write of 0 hit the same flag in the same cycle, the flag ends up 1.
- R9: A flag holds its value while it gets neither a set event nor a write of 0.
- R10: `irq_out` is the OR over implemented flags of flag[i] AND `irq_en[i]`. Bit 5 never counts. The output follows a change of `irq_en` in the same cycle.
- R11: With `FULL_SET`=0, bits 6 and 2 always read 0, ignore their events and never assert `irq_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| timer_wrap | input | 1 | One-cycle strobe on timer counter rollover |
| xfer_done | input | 1 | One-cycle strobe on serial transfer completion |
| ext_pin | input | 5 | Asynchronous external interrupt pins |
| pin_irq_mode | input | 5 | Per-pin enable for interrupt-input use |
| edge_rise | input | 5 | Per-pin edge select: 1 rising, 0 falling |
| wr_en | input | 1 | Write strobe from the bus |
| wr_data | input | 8 | Write data. A 0 clears a set flag |
| irq_en | input | 8 | Per-flag enable for the combined request |
| rd_data | output | 8 | Current register contents |
| irq_out | output | 1 | Combined interrupt request |

## Verification
Strobe sets and software clears show on `rd_data` one edge after they are sampled. The bench drives them at a falling edge and reads 2 ns after the next rising edge. A pin change needs three rising edges: two for the synchroniser and one for the flag. The bench therefore checks the flag both after the second edge, when it must still be 0, and after the third, when it must be 1. `irq_out` is combinational on `irq_en`, so it is read in the same window as the flags it depends on.

// File: rtl/irq_flag_reg.sv
module irq_flag_reg #(
  parameter bit FULL_SET = 1'b1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       timer_wrap,
  input  logic       xfer_done,
  input  logic [4:0] ext_pin,
  input  logic [4:0] pin_irq_mode,
  input  logic [4:0] edge_rise,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  input  logic [7:0] irq_en,
  output logic [7:0] rd_data,
  output logic       irq_out
);
  localparam logic [7:0] IMPL  = FULL_SET ? 8'hDF : 8'h9B;
  localparam logic [7:0] FIXED = 8'h20;

  logic [4:0] s1, s2, s3;
  logic [4:0] rise, fall, pin_hit;
  logic [7:0] flags, set_v, clr_v;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      s1 <= '0;
      s2 <= '0;
      s3 <= '0;
    end else begin
      s1 <= ext_pin;
      s2 <= s1;
      s3 <= s2;
    end

  assign rise    = s2 & ~s3;
  assign fall    = ~s2 & s3;
  assign pin_hit = pin_irq_mode & ((edge_rise & rise) | (~edge_rise & fall));

  assign set_v = {timer_wrap, xfer_done, 1'b0, pin_hit} & IMPL;
  assign clr_v = {8{wr_en}} & ~wr_data & flags;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) flags <= '0;
    else        flags <= (set_v | (flags & ~clr_v)) & IMPL;

  assign rd_data = flags | FIXED;
  assign irq_out = |(flags & irq_en);
endmodule

module irq_flag_reg_chk #(
  parameter bit FULL_SET = 1'b1
) (
  input logic       clk,
  input logic       rst_n,
  input logic       timer_wrap,
  input logic       wr_en,
  input logic [7:0] wr_data,
  input logic [7:0] irq_en,
  input logic [7:0] rd_data,
  input logic       irq_out
);
  a_r3_bit5_one: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[5]);

  a_r2_timer_sets: assert property (@(posedge clk) disable iff (!rst_n)
    timer_wrap |=> rd_data[7]);

  a_r8_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (timer_wrap && wr_en && !wr_data[7]) |=> rd_data[7]);

  a_r6_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data[7] && wr_en && !wr_data[7] && !timer_wrap) |=> !rd_data[7]);

  a_r7_r9_hold_set: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data[7] && !(wr_en && !wr_data[7])) |=> rd_data[7]);

  a_r9_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_data[7] && !timer_wrap) |=> !rd_data[7]);

  a_r10_irq: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out == |(rd_data & irq_en & 8'hDF));

  generate
    if (!FULL_SET) begin : g_lite
      a_r11_reserved: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_data[6] && !rd_data[2]);
    end
  endgenerate
endmodule

bind irq_flag_reg irq_flag_reg_chk #(.FULL_SET(FULL_SET)) u_chk (
  .clk(clk), .rst_n(rst_n), .timer_wrap(timer_wrap), .wr_en(wr_en),
  .wr_data(wr_data), .irq_en(irq_en), .rd_data(rd_data), .irq_out(irq_out)
);

// File: tb/tb_irq_flag_reg.sv
module tb_irq_flag_reg;
  logic       clk = 0, rst_n = 0;
  logic       timer_wrap = 0, xfer_done = 0, wr_en = 0;
  logic [4:0] ext_pin = '0, pin_irq_mode = '0, edge_rise = '0;
  logic [7:0] wr_data = '0, irq_en = '0;
  logic [7:0] rd_data, rd_lite;
  logic       irq_out, irq_lite;
  int errors = 0, checks = 0;

  always #4 clk = ~clk;

  irq_flag_reg dut (
    .clk(clk), .rst_n(rst_n), .timer_wrap(timer_wrap), .xfer_done(xfer_done),
    .ext_pin(ext_pin), .pin_irq_mode(pin_irq_mode), .edge_rise(edge_rise),
    .wr_en(wr_en), .wr_data(wr_data), .irq_en(irq_en),
    .rd_data(rd_data), .irq_out(irq_out));

  irq_flag_reg #(.FULL_SET(1'b0)) dut_lite (
    .clk(clk), .rst_n(rst_n), .timer_wrap(timer_wrap), .xfer_done(xfer_done),
    .ext_pin(ext_pin), .pin_irq_mode(pin_irq_mode), .edge_rise(edge_rise),
    .wr_en(wr_en), .wr_data(wr_data), .irq_en(irq_en),
    .rd_data(rd_lite), .irq_out(irq_lite));

  typedef struct packed {
    logic       tmr;
    logic       xf;
    logic       we;
    logic [7:0] wd;
    logic [7:0] en;
    logic [7:0] exp_rd;
    logic       exp_irq;
  } vec_t;

  localparam vec_t VEC [8] = '{
    '{1'b1, 1'b0, 1'b0, 8'h00, 8'h00, 8'hA0, 1'b0},  // R2 timer
    '{1'b0, 1'b1, 1'b0, 8'h00, 8'h40, 8'hE0, 1'b1},  // R2 serial, R10
    '{1'b0, 1'b0, 1'b1, 8'hFF, 8'h01, 8'hE0, 1'b0},  // R7 write ones
    '{1'b0, 1'b0, 1'b1, 8'h7F, 8'h80, 8'h60, 1'b0},  // R6 clear bit7
    '{1'b1, 1'b0, 1'b1, 8'h00, 8'hFF, 8'hA0, 1'b1},  // R8 set wins
    '{1'b0, 1'b0, 1'b0, 8'h00, 8'h20, 8'hA0, 1'b0},  // R9 hold, R10 bit5
    '{1'b0, 1'b0, 1'b1, 8'hDF, 8'h00, 8'hA0, 1'b0},  // R3 write bit5
    '{1'b0, 1'b0, 1'b1, 8'h00, 8'h00, 8'h20, 1'b0}   // R6 clear all
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic after_edge();
    @(posedge clk);
    #2;
  endtask

  task automatic idle();
    @(negedge clk);
    timer_wrap = 0; xfer_done = 0; wr_en = 0; wr_data = '0;
  endtask

  initial begin
    #(8 * 100000);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #2;
    chk("R1 reset read", rd_data, 8'h20);
    chk("R1 reset irq", {7'd0, irq_out}, 8'h00);
    @(negedge clk);
    rst_n = 1;
    irq_en = 8'hFF;
    after_edge();
    chk("R1 after release", rd_data, 8'h20);

    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      timer_wrap = VEC[i].tmr; xfer_done = VEC[i].xf;
      wr_en = VEC[i].we; wr_data = VEC[i].wd; irq_en = VEC[i].en;
      after_edge();
      chk($sformatf("R2/R3/R6-R10 vec%0d rd", i), rd_data, VEC[i].exp_rd);
      chk($sformatf("R10 vec%0d irq", i), {7'd0, irq_out}, {7'd0, VEC[i].exp_irq});
    end
    idle();

    // R4 rising edge on pin 0
    pin_irq_mode = 5'b01111; edge_rise = 5'b00111; irq_en = 8'h01;
    ext_pin = 5'b00001;
    after_edge();
    after_edge();
    chk("R4 pin0 not yet after 2 edges", rd_data, 8'h20);
    after_edge();
    chk("R4 pin0 rising set", rd_data, 8'h21);
    chk("R10 pin0 irq", {7'd0, irq_out}, 8'h01);
    // R4 pin 3 selects falling: rising edge ignored
    @(negedge clk);
    ext_pin = 5'b01001;
    repeat (4) after_edge();
    chk("R4 pin3 rising ignored", rd_data, 8'h21);
    @(negedge clk);
    ext_pin = 5'b00001;
    after_edge();
    after_edge();
    chk("R4 pin3 not yet", rd_data, 8'h21);
    after_edge();
    chk("R4 pin3 falling set", rd_data, 8'h29);
    // R5 pin 4 not in interrupt mode
    @(negedge clk);
    ext_pin = 5'b10001;
    repeat (4) after_edge();
    @(negedge clk);
    ext_pin = 5'b00001;
    repeat (4) after_edge();
    chk("R5 pin4 disabled", rd_data, 8'h29);
    // R6 selective clear of bit 3 only
    @(negedge clk);
    wr_en = 1; wr_data = 8'hF7;
    after_edge();
    chk("R6 clear bit3 keep bit0", rd_data, 8'h21);
    idle();
    wr_en = 1; wr_data = 8'h00;
    after_edge();
    idle();

    // R11 reduced build
    xfer_done = 1; timer_wrap = 1;
    pin_irq_mode = 5'b00100; edge_rise = 5'b00100; ext_pin = 5'b00100;
    irq_en = 8'h44;
    after_edge();
    idle();
    repeat (3) after_edge();
    chk("R11 lite read", rd_lite, 8'hA0);
    chk("R11 lite irq", {7'd0, irq_lite}, 8'h00);
    chk("R2 full serial+pin2", rd_data, 8'hE4);
    chk("R10 full irq", {7'd0, irq_out}, 8'h01);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule